// File: doc/BRIEF.md
# Dual-Coil Relay Pulse Controller

This block is the digital timing and protection core for driving a two-coil latching relay. It watches two command inputs, one per coil. A command counts only when its input makes a low-to-high transition and then stays high for longer than a configured qualification time. A qualified command energises the matching coil for a bounded time. In follow mode the coil stays on for as long as the input was high. In fixed mode the coil stays on for exactly the configured maximum width. Both modes are capped at that maximum width.

Protection logic makes sure the two coils are never driven together. Commands that qualify together, or whose qualification overlaps, are both thrown away. A command that arrives while a pulse is running is discarded. Deasserting the enable input, or raising either fault input (undervoltage, overtemperature), removes coil drive in the same cycle and returns all state to idle. All time is counted in strobes of the single-cycle `tick` input, so the clock frequency and the time resolution are independent of each other.

Top module: `relay_pulse_ctrl`

## Requirements
- R1: A command starts only from a low-to-high transition of its synchronised input. An input that is already high when reset is released, or when shutdown ends, never starts a pulse.
- R2: A command qualifies only if its input stays high through more than `cfg_qual_ticks` tick-strobed cycles. With `tick` held high, an input high for W cycles produces a pulse exactly when W > `cfg_qual_ticks`; otherwise nothing happens.
- R3: With `tick` held high and no conflict, the coil turns on exactly `cfg_qual_ticks` + 4 clock cycles after the command input rises.
- R4: In follow mode (`cfg_fixed_mode` = 0), the coil stays on for min(W, `cfg_max_ticks`) ticks, where W is the input high time.
- R5: In fixed mode (`cfg_fixed_mode` = 1), a qualified command keeps the coil on for exactly `cfg_max_ticks` ticks, whatever the input width.
- R6: A coil is never on for more than `cfg_max_ticks` ticks, even when its input stays high.
- R7: When both inputs qualify in the same cycle, or one input qualifies while the other is still pending or qualifying, neither coil is driven. If the other input drops before it qualifies, the first command runs with its normal width.
- R8: While a pulse is running, rising edges on either input are discarded. After a pulse ends, a fresh rising edge is needed before a new command can start.
- R9: `en` low, `fault_uv` high or `fault_ot` high forces both coils off in the same cycle and clears all qualification and pulse state. A fault overrides `en` high.
- R10: Qualification and pulse timing advance only on cycles where `tick` is high. With `tick` low, nothing qualifies and a running pulse holds.
- R11: `coil_a` and `coil_b` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base strobe, one cycle wide |
| en | input | 1 | Enable; low forces shutdown |
| fault_uv | input | 1 | Undervoltage fault, active high |
| fault_ot | input | 1 | Overtemperature fault, active high |
| cmd_a | input | 1 | Command input for coil A (asynchronous) |
| cmd_b | input | 1 | Command input for coil B (asynchronous) |
| cfg_qual_ticks | input | CNT_W | Qualification time in ticks (static) |
| cfg_max_ticks | input | CNT_W | Maximum coil on-time in ticks (static) |
| cfg_fixed_mode | input | 1 | 1 = fixed width, 0 = follow input width |
| coil_a | output | 1 | Coil A energise (1 = switch conducting) |
| coil_b | output | 1 | Coil B energise (1 = switch conducting) |

## Verification
Most internal faults show at the ports within one pulse. A qualification counter that is off by one moves the coil's turn-on by a cycle, or decides the boundary width W = `cfg_qual_ticks` the wrong way. A broken on-time counter changes the measured coil width right away. A missing edge or lockout condition shows up as an extra pulse when an input stays high past the end of a pulse, or when a second input rises during a pulse. A wrong arbitration term shows up either as a pulse where a conflict should silence both coils, or as a missing pulse after a short disturbance on the other input. The sweep over qualification time, maximum width, mode and input width therefore samples the turn-on cycle and the exact width of every pulse.

// File: rtl/relay_pkg.sv
`timescale 1ns/1ps
package relay_pkg;

  localparam int RLY_CNT_W = 19;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_QUAL = 2'd1,
    CH_PEND = 2'd2,
    CH_FIRE = 2'd3
  } ch_state_e;

  // saturating increment
  function automatic int unsigned held_sat_inc(input int unsigned v, input int unsigned cap);
    return (v >= cap) ? cap : v + 32'd1;
  endfunction

  // held time strictly longer than the qualification setting
  function automatic logic qual_passed(input int unsigned held, input int unsigned qual);
    return held > qual;
  endfunction

  // on-time target for the running pulse
  function automatic int unsigned pulse_limit(input logic fixed_mode, input int unsigned held,
                                              input int unsigned maxw);
    if (fixed_mode) return maxw;
    return (held < maxw) ? held : maxw;
  endfunction

  function automatic logic width_reached(input int unsigned elapsed_next, input int unsigned limit);
    return elapsed_next >= limit;
  endfunction

endpackage

// File: rtl/relay_in_edge.sv
`timescale 1ns/1ps
module relay_in_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // reset to "high" so a line already high at reset release is not an edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level = sync_q[STAGES-1];
  assign rise  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/relay_qual_chan.sv
`timescale 1ns/1ps
module relay_qual_chan
  import relay_pkg::*;
#(
  parameter int CNT_W = RLY_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             tick,
  input  logic             level,
  input  logic             rise,
  input  logic             allow_start,
  input  logic             reject,
  input  logic             launch,
  input  logic             done,
  input  logic [CNT_W-1:0] cfg_qual,
  output ch_state_e        state,
  output logic             hit,
  output logic [CNT_W-1:0] held_next
);
  localparam int unsigned HELD_CAP = (CNT_W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << CNT_W) - 32'd1);

  ch_state_e        nxt;
  logic             live;
  logic             start;
  logic             count_en;
  logic [CNT_W-1:0] held;

  assign start     = (state == CH_IDLE) & rise & allow_start;
  assign count_en  = (state != CH_IDLE) & live & level & tick;
  assign held_next = count_en ? CNT_W'(held_sat_inc(32'(held), HELD_CAP)) : held;
  assign hit       = (state == CH_QUAL) & count_en & qual_passed(32'(held_next), 32'(cfg_qual));

  always_comb begin
    nxt = state;
    unique case (state)
      CH_IDLE: if (start) nxt = CH_QUAL;
      CH_QUAL: begin
        if (!level)    nxt = CH_IDLE;
        else if (hit)  nxt = reject ? CH_IDLE : CH_PEND;
      end
      CH_PEND: begin
        if (reject)      nxt = CH_IDLE;
        else if (launch) nxt = CH_FIRE;
      end
      CH_FIRE: if (done) nxt = CH_IDLE;
      default: nxt = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || kill) begin
      state <= CH_IDLE;
      live  <= 1'b0;
      held  <= '0;
    end else begin
      state <= nxt;
      if (start) begin
        held <= tick ? CNT_W'(1) : '0;
        live <= 1'b1;
      end else begin
        held <= held_next;
        if (!level) live <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/relay_pulse_timer.sv
`timescale 1ns/1ps
module relay_pulse_timer
  import relay_pkg::*;
#(
  parameter int CNT_W = RLY_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             tick,
  input  logic             start,
  input  logic             firing,
  input  logic             fixed_mode,
  input  logic [CNT_W-1:0] held_next,
  input  logic [CNT_W-1:0] cfg_max,
  output logic             done
);
  localparam int unsigned ON_CAP = (CNT_W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << CNT_W) - 32'd1);

  logic [CNT_W-1:0] on_cnt;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(pulse_limit(fixed_mode, 32'(held_next), 32'(cfg_max)));
  assign done  = firing & tick & width_reached(32'(on_cnt) + 32'd1, 32'(limit));

  always_ff @(posedge clk) begin
    if (!rst_n || kill)       on_cnt <= '0;
    else if (start)           on_cnt <= '0;
    else if (firing && tick)  on_cnt <= CNT_W'(held_sat_inc(32'(on_cnt), ON_CAP));
  end
endmodule

// File: rtl/relay_pulse_ctrl.sv
`timescale 1ns/1ps
module relay_pulse_ctrl
  import relay_pkg::*;
#(
  parameter int CNT_W       = RLY_CNT_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             fault_uv,
  input  logic             fault_ot,
  input  logic             cmd_a,
  input  logic             cmd_b,
  input  logic [CNT_W-1:0] cfg_qual_ticks,
  input  logic [CNT_W-1:0] cfg_max_ticks,
  input  logic             cfg_fixed_mode,
  output logic             coil_a,
  output logic             coil_b
);
  localparam int NCH = 2;

  logic             kill;
  logic [NCH-1:0]   cmd_in, lvl, rise;
  logic [NCH-1:0]   ch_hit, ch_pend, ch_fire, ch_qual, ch_go, ch_allow;
  logic [CNT_W-1:0] ch_held [NCH];
  ch_state_e        ch_st   [NCH];
  logic             conflict, pulse_start, pulse_done, firing;
  logic [CNT_W-1:0] held_owner;

  assign kill   = ~en | fault_uv | fault_ot;
  assign cmd_in = {cmd_b, cmd_a};

  // both qualifying at once, or one qualifying against a pending other
  assign conflict = (ch_hit[0] & ch_hit[1]) | (ch_hit[0] & ch_pend[1]) | (ch_pend[0] & ch_hit[1]);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    relay_in_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (cmd_in[g]),
      .level (lvl[g]),
      .rise  (rise[g])
    );

    relay_qual_chan #(.CNT_W(CNT_W)) u_qual (
      .clk         (clk),
      .rst_n       (rst_n),
      .kill        (kill),
      .tick        (tick),
      .level       (lvl[g]),
      .rise        (rise[g]),
      .allow_start (ch_allow[g]),
      .reject      (conflict),
      .launch      (ch_go[g]),
      .done        (pulse_done),
      .cfg_qual    (cfg_qual_ticks),
      .state       (ch_st[g]),
      .hit         (ch_hit[g]),
      .held_next   (ch_held[g])
    );

    assign ch_pend[g]  = (ch_st[g] == CH_PEND);
    assign ch_fire[g]  = (ch_st[g] == CH_FIRE);
    assign ch_qual[g]  = (ch_st[g] == CH_QUAL);
    assign ch_go[g]    = ch_pend[g] & ~ch_qual[NCH-1-g] & ~conflict;
    assign ch_allow[g] = ~ch_pend[NCH-1-g] & ~ch_fire[NCH-1-g];
  end

  assign pulse_start = |ch_go;
  assign firing      = |ch_fire;
  assign held_owner  = ch_fire[1] ? ch_held[1] : ch_held[0];

  relay_pulse_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .kill       (kill),
    .tick       (tick),
    .start      (pulse_start),
    .firing     (firing),
    .fixed_mode (cfg_fixed_mode),
    .held_next  (held_owner),
    .cfg_max    (cfg_max_ticks),
    .done       (pulse_done)
  );

  assign coil_a = ch_fire[0] & ~kill;
  assign coil_b = ch_fire[1] & ~kill;
endmodule

// File: rtl/relay_pulse_ctrl_chk.sv
`timescale 1ns/1ps
module relay_pulse_ctrl_chk #(
  parameter int CNT_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             kill,
  input logic             coil_a,
  input logic             coil_b,
  input logic [1:0]       fire,
  input logic [1:0]       pend,
  input logic [1:0]       qual,
  input logic             conflict,
  input logic [CNT_W-1:0] cfg_max_ticks
);
  logic [CNT_W:0] on_ticks;

  always_ff @(posedge clk) begin
    if (!rst_n || fire == 2'b00) on_ticks <= '0;
    else if (tick)               on_ticks <= on_ticks + 1'b1;
  end

  AST_COILS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(coil_a && coil_b)); // R11
  AST_SHUTDOWN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (fire == 2'b00 && pend == 2'b00 && qual == 2'b00)); // R9
  AST_WIDTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    on_ticks <= {1'b0, cfg_max_ticks}); // R6
  AST_CONFLICT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> (pend == 2'b00 && fire == 2'b00)); // R7
  AST_FIRE_A_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fire[0]) |-> $past(pend[0])); // R2
  AST_FIRE_B_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fire[1]) |-> $past(pend[1])); // R2
  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire != 2'b00) |-> (qual == 2'b00)); // R8
endmodule

bind relay_pulse_ctrl relay_pulse_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick          (tick),
  .kill          (kill),
  .coil_a        (coil_a),
  .coil_b        (coil_b),
  .fire          (ch_fire),
  .pend          (ch_pend),
  .qual          (ch_qual),
  .conflict      (conflict),
  .cfg_max_ticks (cfg_max_ticks)
);

// File: tb/relay_pulse_ctrl_bench.sv
`timescale 1ns/1ps
module relay_pulse_ctrl_bench;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n, tick, en, fault_uv, fault_ot, cmd_a, cmd_b, cfg_fixed_mode;
  logic [CW-1:0] cfg_qual_ticks, cfg_max_ticks;
  logic          coil_a, coil_b;
  int            n_chk = 0;
  int            n_bad = 0;

  always #10 clk = ~clk;

  relay_pulse_ctrl #(.CNT_W(CW)) u_relay_pulse_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .fault_uv(fault_uv), .fault_ot(fault_ot),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .cfg_qual_ticks(cfg_qual_ticks), .cfg_max_ticks(cfg_max_ticks),
    .cfg_fixed_mode(cfg_fixed_mode), .coil_a(coil_a), .coil_b(coil_b)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // drives the patterns one bit per cycle, samples coils after each falling edge
  task automatic run_pat(input logic [63:0] pa, input logic [63:0] pb, input int win,
                         output int fa, output int ca, output int fb, output int cb, output int ra);
    logic pv;
    pv = 1'b0;
    fa = -1; fb = -1; ca = 0; cb = 0; ra = 0;
    cmd_a = pa[0];
    cmd_b = pb[0];
    for (int i = 1; i <= win; i++) begin
      @(negedge clk);
      #1;
      if (coil_a) begin
        if (fa < 0) fa = i;
        ca++;
        if (!pv) ra++;
      end
      pv = coil_a;
      if (coil_b) begin
        if (fb < 0) fb = i;
        cb++;
      end
      cmd_a = (i < 64) ? pa[i] : 1'b0;
      cmd_b = (i < 64) ? pb[i] : 1'b0;
    end
    cmd_a = 1'b0;
    cmd_b = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int fa, ca, fb, cb, ra, cnt;
    rst_n = 1'b0; tick = 1'b1; en = 1'b1; fault_uv = 1'b0; fault_ot = 1'b0;
    cmd_a = 1'b1; cmd_b = 1'b0; cfg_fixed_mode = 1'b0;
    cfg_qual_ticks = CW'(3); cfg_max_ticks = CW'(5);
    idle(4);
    rst_n = 1'b1;
    chk("R9 reset coil_a off", int'(coil_a), 0);
    chk("R9 reset coil_b off", int'(coil_b), 0);
    // R1: input high across reset release never fires
    cnt = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk); #1;
      if (coil_a) cnt++;
    end
    chk("R1 high at reset release", cnt, 0);
    cmd_a = 1'b0;
    idle(4);

    // sweep: qualification, max width, mode, input width, both channels
    for (int q = 1; q <= 3; q++) begin
      for (int m = 1; m <= 5; m++) begin
        for (int fm = 0; fm <= 1; fm++) begin
          for (int w = 1; w <= 7; w++) begin
            logic [63:0] pat;
            int ch, exp_w, got_f, got_c, oth;
            pat = (64'd1 << w) - 64'd1;
            ch  = w % 2;
            cfg_qual_ticks = CW'(q);
            cfg_max_ticks  = CW'(m);
            cfg_fixed_mode = fm[0];
            idle(3);
            if (ch == 0) run_pat(pat, 64'd0, w + q + m + 6, fa, ca, fb, cb, ra);
            else         run_pat(64'd0, pat, w + q + m + 6, fa, ca, fb, cb, ra);
            got_f = (ch == 0) ? fa : fb;
            got_c = (ch == 0) ? ca : cb;
            oth   = (ch == 0) ? cb : ca;
            if (w <= q)      exp_w = 0;
            else if (fm == 1) exp_w = m;
            else              exp_w = (w < m) ? w : m;
            if (w <= q)            chk("R2 short pulse ignored", got_c, 0);
            else if (fm == 1)      chk("R5 fixed width", got_c, exp_w);
            else if (w > m)        chk("R6 follow capped", got_c, exp_w);
            else                   chk("R4 follow width", got_c, exp_w);
            if (exp_w > 0) chk("R3 turn-on latency", got_f, q + 4);
            chk("R11 other coil idle", oth, 0);
          end
        end
      end
    end

    cfg_qual_ticks = CW'(3); cfg_max_ticks = CW'(5); cfg_fixed_mode = 1'b0;
    idle(3);
    run_pat(64'h3F, 64'h3F, 20, fa, ca, fb, cb, ra);
    chk("R7 simultaneous A", ca, 0);
    chk("R7 simultaneous B", cb, 0);
    idle(3);
    run_pat(64'h7F, 64'h0C, 25, fa, ca, fb, cb, ra);
    chk("R7 short disturbance A runs", ca, 5);
    chk("R7 short disturbance B idle", cb, 0);
    idle(3);
    run_pat(64'h3F, 64'h1FE, 25, fa, ca, fb, cb, ra);
    chk("R7 overlap A", ca, 0);
    chk("R7 overlap B", cb, 0);
    idle(3);
    run_pat(64'h1F, 64'h3F00, 25, fa, ca, fb, cb, ra);
    chk("R8 lockout A width", ca, 5);
    chk("R8 lockout B ignored", cb, 0);
    idle(3);

    // R8: re-rise on own input during a fixed pulse is discarded
    cfg_qual_ticks = CW'(1); cfg_max_ticks = CW'(6); cfg_fixed_mode = 1'b1;
    idle(3);
    run_pat(64'h1B, 64'd0, 20, fa, ca, fb, cb, ra);
    chk("R8 re-rise width", ca, 6);
    chk("R8 re-rise single pulse", ra, 1);
    idle(3);

    // R8: input still high after a capped pulse gives no second pulse
    cfg_qual_ticks = CW'(1); cfg_max_ticks = CW'(3); cfg_fixed_mode = 1'b0;
    run_pat(64'hFFFFF, 64'd0, 30, fa, ca, fb, cb, ra);
    chk("R8 held input single pulse", ra, 1);
    chk("R6 held input capped", ca, 3);
    idle(3);

    // R9: enable low mid-pulse, then re-enable with input still high
    cfg_qual_ticks = CW'(2); cfg_max_ticks = CW'(6); cfg_fixed_mode = 1'b0;
    idle(2);
    cmd_a = 1'b1;
    idle(7);
    chk("R4 pulse running before shutdown", int'(coil_a), 1);
    en = 1'b0;
    #1;
    chk("R9 enable low drops coil", int'(coil_a), 0);
    idle(3);
    en = 1'b1;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      if (coil_a) cnt++;
    end
    chk("R1 high at re-enable", cnt, 0);
    cmd_a = 1'b0;
    idle(3);

    // R9: overtemperature mid-pulse with enable high
    cmd_b = 1'b1;
    idle(7);
    chk("R4 pulse B running", int'(coil_b), 1);
    fault_ot = 1'b1;
    #1;
    chk("R9 overtemp drops coil", int'(coil_b), 0);
    cmd_b = 1'b0;
    idle(3);
    fault_ot = 1'b0;
    idle(3);

    // R9: undervoltage overrides enable
    fault_uv = 1'b1;
    run_pat(64'h3FF, 64'd0, 20, fa, ca, fb, cb, ra);
    chk("R9 undervoltage blocks", ca, 0);
    fault_uv = 1'b0;
    idle(3);

    // R10: tick low, no qualification
    tick = 1'b0;
    run_pat(64'hFFFFF, 64'd0, 30, fa, ca, fb, cb, ra);
    chk("R10 no tick no pulse", ca, 0);
    tick = 1'b1;
    idle(3);

    // R10: tick low holds a running fixed pulse
    cfg_qual_ticks = CW'(1); cfg_max_ticks = CW'(2); cfg_fixed_mode = 1'b1;
    idle(2);
    cmd_a = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk); #1;
      if (i == 2) cmd_a = 1'b0;
    end
    chk("R3 fixed turn-on", int'(coil_a), 1);
    tick = 1'b0;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #1;
      if (coil_a) cnt++;
    end
    chk("R10 pulse held while tick low", cnt, 10);
    tick = 1'b1;
    cnt = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      if (coil_a) cnt++;
    end
    chk("R10 pulse resumes and ends", cnt, 1);

    idle(3);
    finish_run();
  end
endmodule